// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Flags

This block holds a small bank of single-bit ownership flags that two independent agents (a left port and a right port) use to claim and hand back shared resources. A port asks for a flag by writing 0 to it and then reads the flag back: a read of 0 means the port holds the flag, a read of 1 means it does not (yet). The holder gives the flag back by writing 1. If the other side asked while the flag was held, its request is remembered and it becomes the holder at the moment of release, with no further write.

Each port has an active-low semaphore select, an active-low memory chip enable that must be inactive for a flag access, a read/write line whose low-to-high transition commits a write, an active-low output enable, two active-low byte-lane selects, a flag address, a one-bit write value and a wide read data bus. All inputs are sampled on the rising edge of a shared clock. When both ports ask for the same free flag on the same edge, the left port wins and the right request is kept pending.

Top module: `two_port_sem_flags`

## Requirements
- R1: After reset every flag is free: a legal read of any flag from either port returns all ones.
- R2: The read bus is all zeros unless the port's access is legal (select low, chip enable high), read/write is high and output enable is low.
- R3: A legal read drives the addressed flag's view onto every bit of the read bus; the view is 0 only for the port that holds the flag.
- R4: A write takes effect only at a clock edge where read/write is sampled high, was sampled low on the previous edge, and the access is legal at that edge; the flag is chosen by the address and its new request value is the one-bit write input (0 asks, 1 releases). A low-to-high change while deselected does nothing.
- R5: Writing 0 to a free flag makes the writer the holder from the next cycle: it reads 0, the other port reads 1.
- R6: Writing 0 to a flag held by the other port is latched as a pending request; when the holder writes 1, the waiting port becomes the holder and reads 0 in the next cycle.
- R7: When both ports write 0 to the same free flag at the same edge, the left port becomes the holder and the right request stays pending.
- R8: A write of 1 from a port that neither holds nor waits for a flag leaves both ports' views unchanged; a write of 1 from a waiting port withdraws its request.
- R9: Select low together with chip enable low is illegal: the read bus stays zero and any write commit in that state is ignored.
- R10: With the default lane option, the byte-lane selects have no effect on flag reads or writes.
- R11: Flags are independent: a write to one address leaves every other flag's view unchanged.
- R12: No flag ever reads 0 on both ports at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all inputs sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sel_n | input | 1 | Left semaphore select, active low |
| l_ce_n | input | 1 | Left memory chip enable, active low; must be high for a flag access |
| l_rw | input | 1 | Left read (1) / write (0); rising transition commits a write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ub_n | input | 1 | Left upper byte-lane select, active low |
| l_lb_n | input | 1 | Left lower byte-lane select, active low |
| l_addr | input | 3 | Left flag address |
| l_wbit | input | 1 | Left write value (0 request, 1 release) |
| l_rdata | output | 18 | Left read data |
| r_sel_n | input | 1 | Right semaphore select, active low |
| r_ce_n | input | 1 | Right memory chip enable, active low; must be high for a flag access |
| r_rw | input | 1 | Right read (1) / write (0); rising transition commits a write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ub_n | input | 1 | Right upper byte-lane select, active low |
| r_lb_n | input | 1 | Right lower byte-lane select, active low |
| r_addr | input | 3 | Right flag address |
| r_wbit | input | 1 | Right write value (0 request, 1 release) |
| r_rdata | output | 18 | Right read data |

## Verification
Directed sequences take a single flag through claim, contended claim, hand-over on release, withdrawal and same-edge collision, which separates a correct pending latch from a design that drops or double-grants a waiting request. Illegal enable combinations, a rising read/write line after deselect, and byte-lane selects held inactive tell apart a commit qualified at the edge from one taken on level or from an unqualified edge. A long random phase restricted to four flags, with forced same-address writes from both sides, compares every flag against an independent ownership model and checks that no address ever reads 0 on both ports.

// File: rtl/sem_flag_pkg.sv
package sem_flag_pkg;

   // holder of one flag
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } sem_owner_e;

endpackage

// File: rtl/sem_port_front.sv
// Per-port front end: access qualification, write-commit edge detection,
// address decode into request/release strobes and read data formatting.
module sem_port_front #(
   parameter int ADDR_W    = 3,
   parameter int DATA_W    = 18,
   parameter int LOWER_W   = 9,
   parameter bit LANE_GATE = 1'b0,
   localparam int NUM_FLAGS = 1 << ADDR_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sel_n,
   input  logic                 ce_n,
   input  logic                 rw,
   input  logic                 oe_n,
   input  logic                 ub_n,
   input  logic                 lb_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 wbit,
   input  logic [NUM_FLAGS-1:0] flag_view,
   output logic [NUM_FLAGS-1:0] req_vec,
   output logic [NUM_FLAGS-1:0] rel_vec,
   output logic                 wr_evt,
   output logic [DATA_W-1:0]    rdata
);

   localparam int UPPER_W = DATA_W - LOWER_W;

   logic                 rw_d;
   logic                 access_ok;
   logic                 rd_en;
   logic                 view_bit;
   logic [NUM_FLAGS-1:0] addr_hot;

   // previous read/write level; idle level is high so reset never looks like an edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rw_d <= 1'b1;
      else        rw_d <= rw;
   end

   assign access_ok = ~sel_n & ce_n;
   assign wr_evt    = access_ok & rw & ~rw_d;
   assign addr_hot  = NUM_FLAGS'(1) << addr;

   always_comb begin
      req_vec = '0;
      rel_vec = '0;
      if (wr_evt) begin
         if (wbit) rel_vec = addr_hot;
         else      req_vec = addr_hot;
      end
   end

   assign rd_en    = access_ok & rw & ~oe_n;
   assign view_bit = flag_view[addr];

   generate
      if (LANE_GATE) begin : g_lane_gated
         assign rdata[LOWER_W-1:0]      = (rd_en & ~lb_n) ? {LOWER_W{view_bit}} : '0;
         assign rdata[DATA_W-1:LOWER_W] = (rd_en & ~ub_n) ? {UPPER_W{view_bit}} : '0;
      end else begin : g_lane_free
         logic unused_lanes;
         assign unused_lanes = ^{ub_n, lb_n};
         assign rdata        = rd_en ? {DATA_W{view_bit}} : '0;
      end
   endgenerate

endmodule

// File: rtl/sem_flag_cell.sv
// One flag: holder, and a pending-request bit for each side.
module sem_flag_cell
   import sem_flag_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic l_req,
   input  logic l_rel,
   input  logic r_req,
   input  logic r_rel,
   output logic l_view,
   output logic r_view
);

   sem_owner_e own_q, own_d;
   logic       lp_q, lp_d;
   logic       rp_q, rp_d;

   always_comb begin
      own_d = own_q;
      lp_d  = lp_q;
      rp_d  = rp_q;
      unique case (own_q)
         OWN_NONE: begin
            lp_d = 1'b0;
            rp_d = 1'b0;
            if (l_req) begin
               own_d = OWN_LEFT;   // left wins a same-edge collision
               rp_d  = r_req;
            end else if (r_req) begin
               own_d = OWN_RIGHT;
            end
         end
         OWN_LEFT: begin
            if (l_rel) begin
               rp_d  = 1'b0;
               own_d = ((rp_q | r_req) & ~r_rel) ? OWN_RIGHT : OWN_NONE;
            end else begin
               if (r_req) rp_d = 1'b1;
               if (r_rel) rp_d = 1'b0;
            end
         end
         OWN_RIGHT: begin
            if (r_rel) begin
               lp_d  = 1'b0;
               own_d = ((lp_q | l_req) & ~l_rel) ? OWN_LEFT : OWN_NONE;
            end else begin
               if (l_req) lp_d = 1'b1;
               if (l_rel) lp_d = 1'b0;
            end
         end
         default: begin
            own_d = OWN_NONE;
            lp_d  = 1'b0;
            rp_d  = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q <= OWN_NONE;
         lp_q  <= 1'b0;
         rp_q  <= 1'b0;
      end else begin
         own_q <= own_d;
         lp_q  <= lp_d;
         rp_q  <= rp_d;
      end
   end

   assign l_view = (own_q != OWN_LEFT);
   assign r_view = (own_q != OWN_RIGHT);

endmodule

// File: rtl/two_port_sem_flags.sv
module two_port_sem_flags #(
   parameter int ADDR_W    = 3,
   parameter int DATA_W    = 18,
   parameter int LOWER_W   = 9,
   parameter bit LANE_GATE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sel_n,
   input  logic              l_ce_n,
   input  logic              l_rw,
   input  logic              l_oe_n,
   input  logic              l_ub_n,
   input  logic              l_lb_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              l_wbit,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              r_sel_n,
   input  logic              r_ce_n,
   input  logic              r_rw,
   input  logic              r_oe_n,
   input  logic              r_ub_n,
   input  logic              r_lb_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              r_wbit,
   output logic [DATA_W-1:0] r_rdata
);

   localparam int NUM_FLAGS = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
         $error("two_port_sem_flags: ADDR_W must lie in 1..8");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("two_port_sem_flags: DATA_W must be at least 2");
      end
      if (LOWER_W < 1 || LOWER_W >= DATA_W) begin : g_bad_lane
         $error("two_port_sem_flags: LOWER_W must lie in 1..DATA_W-1");
      end
   endgenerate

   logic [NUM_FLAGS-1:0] l_view, r_view;
   logic [NUM_FLAGS-1:0] l_req_vec, l_rel_vec, r_req_vec, r_rel_vec;
   logic                 l_wr_evt, r_wr_evt;

   sem_port_front #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOWER_W(LOWER_W), .LANE_GATE(LANE_GATE)
   ) u_left (
      .clk(clk), .rst_n(rst_n),
      .sel_n(l_sel_n), .ce_n(l_ce_n), .rw(l_rw), .oe_n(l_oe_n),
      .ub_n(l_ub_n), .lb_n(l_lb_n), .addr(l_addr), .wbit(l_wbit),
      .flag_view(l_view), .req_vec(l_req_vec), .rel_vec(l_rel_vec),
      .wr_evt(l_wr_evt), .rdata(l_rdata)
   );

   sem_port_front #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOWER_W(LOWER_W), .LANE_GATE(LANE_GATE)
   ) u_right (
      .clk(clk), .rst_n(rst_n),
      .sel_n(r_sel_n), .ce_n(r_ce_n), .rw(r_rw), .oe_n(r_oe_n),
      .ub_n(r_ub_n), .lb_n(r_lb_n), .addr(r_addr), .wbit(r_wbit),
      .flag_view(r_view), .req_vec(r_req_vec), .rel_vec(r_rel_vec),
      .wr_evt(r_wr_evt), .rdata(r_rdata)
   );

   generate
      for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
         sem_flag_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_req(l_req_vec[gi]), .l_rel(l_rel_vec[gi]),
            .r_req(r_req_vec[gi]), .r_rel(r_rel_vec[gi]),
            .l_view(l_view[gi]), .r_view(r_view[gi])
         );
      end
   endgenerate

endmodule

// File: rtl/two_port_sem_flags_chk.sv
module two_port_sem_flags_chk #(
   parameter int ADDR_W    = 3,
   parameter int DATA_W    = 18,
   parameter bit LANE_GATE = 1'b0,
   localparam int NUM_FLAGS = 1 << ADDR_W
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 l_sel_n,
   input logic                 l_ce_n,
   input logic                 l_rw,
   input logic                 l_oe_n,
   input logic [ADDR_W-1:0]    l_addr,
   input logic                 l_wbit,
   input logic [DATA_W-1:0]    l_rdata,
   input logic                 r_sel_n,
   input logic                 r_ce_n,
   input logic                 r_rw,
   input logic                 r_oe_n,
   input logic [ADDR_W-1:0]    r_addr,
   input logic                 r_wbit,
   input logic [DATA_W-1:0]    r_rdata,
   input logic [NUM_FLAGS-1:0] l_view,
   input logic [NUM_FLAGS-1:0] r_view,
   input logic                 l_wr_evt,
   input logic                 r_wr_evt
);

   logic l_rd_ok, r_rd_ok;
   assign l_rd_ok = ~l_sel_n & l_ce_n & l_rw & ~l_oe_n;
   assign r_rd_ok = ~r_sel_n & r_ce_n & r_rw & ~r_oe_n;

   // R2: bus idle when no legal read
   p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_rd_ok |-> l_rdata == '0) and (!r_rd_ok |-> r_rdata == '0));

   // R9: illegal enable pair keeps the bus idle
   p_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_sel_n && !l_ce_n) |-> (l_rdata == '0 && !l_wr_evt));

   // R4: flag views change only after a committed write
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_wr_evt && !r_wr_evt) |=> ($stable(l_view) && $stable(r_view)));

   // R7: same-edge request on a free flag goes to the left side
   p_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (l_wr_evt && r_wr_evt && l_addr == r_addr && !l_wbit && !r_wbit &&
       l_view[l_addr] && r_view[l_addr])
      |=> (!l_view[$past(l_addr)] && r_view[$past(l_addr)]));

   // R12: two reads of one address never both report ownership
   p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (l_rd_ok && r_rd_ok && l_addr == r_addr) |-> (l_rdata[0] || r_rdata[0]));

   generate
      if (!LANE_GATE) begin : g_lane_chk
         // R3: every bit carries the same flag value
         p_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (l_rdata == {DATA_W{l_rdata[0]}}) && (r_rdata == {DATA_W{r_rdata[0]}}));
      end
   endgenerate

endmodule

bind two_port_sem_flags two_port_sem_flags_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_GATE(LANE_GATE)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .l_sel_n(l_sel_n), .l_ce_n(l_ce_n), .l_rw(l_rw), .l_oe_n(l_oe_n),
   .l_addr(l_addr), .l_wbit(l_wbit), .l_rdata(l_rdata),
   .r_sel_n(r_sel_n), .r_ce_n(r_ce_n), .r_rw(r_rw), .r_oe_n(r_oe_n),
   .r_addr(r_addr), .r_wbit(r_wbit), .r_rdata(r_rdata),
   .l_view(l_view), .r_view(r_view),
   .l_wr_evt(l_wr_evt), .r_wr_evt(r_wr_evt)
);

// File: tb/two_port_sem_flags_tb_top.sv
module two_port_sem_flags_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic       l_sel_n, l_ce_n, l_rw, l_oe_n, l_ub_n, l_lb_n, l_wbit;
   logic [2:0] l_addr;
   logic [17:0] l_rdata;
   logic       r_sel_n, r_ce_n, r_rw, r_oe_n, r_ub_n, r_lb_n, r_wbit;
   logic [2:0] r_addr;
   logic [17:0] r_rdata;

   two_port_sem_flags dut_i (
      .clk(clk), .rst_n(rst_n),
      .l_sel_n(l_sel_n), .l_ce_n(l_ce_n), .l_rw(l_rw), .l_oe_n(l_oe_n),
      .l_ub_n(l_ub_n), .l_lb_n(l_lb_n), .l_addr(l_addr), .l_wbit(l_wbit),
      .l_rdata(l_rdata),
      .r_sel_n(r_sel_n), .r_ce_n(r_ce_n), .r_rw(r_rw), .r_oe_n(r_oe_n),
      .r_ub_n(r_ub_n), .r_lb_n(r_lb_n), .r_addr(r_addr), .r_wbit(r_wbit),
      .r_rdata(r_rdata)
   );

   typedef struct {
      bit          port;
      logic [17:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;
   logic  bs     = 1'b0;   // byte-lane select level used by drivers

   // independent ownership model: 0 free, 1 left, 2 right
   int own[8];
   bit lpend[8], rpend[8];

   function automatic logic [17:0] exp_of(bit port, int a);
      logic v;
      v = (own[a] == (port ? 2 : 1)) ? 1'b0 : 1'b1;
      return {18{v}};
   endfunction

   function automatic void model_apply(bit len, int la, bit lv, bit ren, int ra, bit rv);
      for (int a = 0; a < 8; a++) begin
         bit lq, lr, rq, rr;
         lq = len && la == a && !lv;  lr = len && la == a && lv;
         rq = ren && ra == a && !rv;  rr = ren && ra == a && rv;
         if (own[a] == 0) begin
            lpend[a] = 0; rpend[a] = 0;
            if (lq) begin own[a] = 1; rpend[a] = rq; end
            else if (rq) own[a] = 2;
         end else if (own[a] == 1) begin
            if (lr) begin
               own[a] = ((rpend[a] || rq) && !rr) ? 2 : 0;
               rpend[a] = 0;
            end else begin
               if (rq) rpend[a] = 1;
               if (rr) rpend[a] = 0;
            end
         end else begin
            if (rr) begin
               own[a] = ((lpend[a] || lq) && !lr) ? 1 : 0;
               lpend[a] = 0;
            end else begin
               if (lq) lpend[a] = 1;
               if (lr) lpend[a] = 0;
            end
         end
      end
   endfunction

   task automatic set_l(input logic s, c, w, o, u, b, input logic [2:0] a, input logic d);
      l_sel_n = s; l_ce_n = c; l_rw = w; l_oe_n = o; l_ub_n = u; l_lb_n = b;
      l_addr = a; l_wbit = d;
   endtask

   task automatic set_r(input logic s, c, w, o, u, b, input logic [2:0] a, input logic d);
      r_sel_n = s; r_ce_n = c; r_rw = w; r_oe_n = o; r_ub_n = u; r_lb_n = b;
      r_addr = a; r_wbit = d;
   endtask

   task automatic idle_both();
      set_l(1, 1, 1, 1, 1, 1, 3'd0, 1'b0);
      set_r(1, 1, 1, 1, 1, 1, 3'd0, 1'b0);
   endtask

   task automatic push(input bit port, input logic [17:0] e, input string tag);
      item_t it;
      it.port = port; it.exp = e; it.tag = tag;
      q.push_back(it);
   endtask

   // driver: simultaneous (or single) write on the two ports
   task automatic wr2(input bit len, input int la, input bit lv,
                      input bit ren, input int ra, input bit rv);
      @(negedge clk);
      if (len) set_l(0, 1, 0, 1, bs, bs, 3'(la), lv); else set_l(1, 1, 1, 1, 1, 1, 3'd0, 1'b0);
      if (ren) set_r(0, 1, 0, 1, bs, bs, 3'(ra), rv); else set_r(1, 1, 1, 1, 1, 1, 3'd0, 1'b0);
      @(negedge clk);
      if (len) l_rw = 1'b1;
      if (ren) r_rw = 1'b1;
      @(negedge clk);
      idle_both();
      model_apply(len, la, lv, ren, ra, rv);
   endtask

   // driver: legal read on both ports, expectations go to the scoreboard
   task automatic rd2(input int la, input int ra, input string tag);
      @(negedge clk);
      set_l(0, 1, 1, 0, bs, bs, 3'(la), 1'b0);
      set_r(0, 1, 1, 0, bs, bs, 3'(ra), 1'b0);
      push(0, exp_of(0, la), tag);
      push(1, exp_of(1, ra), tag);
   endtask

   task automatic rd_all(input string tag);
      for (int a = 0; a < 8; a++) rd2(a, a, tag);
   endtask

   // monitor: pops expectations and compares one ns before the next edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            item_t it;
            logic [17:0] act;
            it  = q.pop_front();
            act = it.port ? r_rdata : l_rdata;
            checks++;
            if (act !== it.exp) begin
               fails++;
               $display("FAIL %s port=%0d actual=%h expected=%h", it.tag, it.port, act, it.exp);
            end
         end
         if (rst_n && !l_sel_n && l_ce_n && l_rw && !l_oe_n &&
             !r_sel_n && r_ce_n && r_rw && !r_oe_n && l_addr == r_addr) begin
            checks++;
            if (l_rdata[0] == 1'b0 && r_rdata[0] == 1'b0) begin
               fails++;
               $display("FAIL R12 addr=%0d actual=both_zero expected=at_most_one_zero", l_addr);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R12 watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < 8; a++) begin own[a] = 0; lpend[a] = 0; rpend[a] = 0; end
      idle_both();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      push(0, 18'h0, "R2_idle_after_reset");
      push(1, 18'h0, "R2_idle_after_reset");

      rd_all("R1_reset_free");

      // R5 claim of a free flag, R3 full-width read
      wr2(1, 2, 0, 0, 0, 0);
      rd_all("R5_R3_R11_left_claims_2");

      // R6 pending request and hand-over on release
      wr2(0, 0, 0, 1, 2, 0);
      rd2(2, 2, "R6_right_waits");
      wr2(1, 2, 1, 0, 0, 0);
      rd2(2, 2, "R6_handover_to_right");

      // R8 stray release by a non-holder, then withdrawal of a pending request
      wr2(1, 2, 1, 0, 0, 0);
      rd2(2, 2, "R8_stray_release");
      wr2(1, 2, 0, 0, 0, 0);
      wr2(1, 2, 1, 0, 0, 0);
      wr2(0, 0, 0, 1, 2, 1);
      rd2(2, 2, "R8_withdrawn_request");

      // R7 same-edge collision
      wr2(1, 5, 0, 1, 5, 0);
      rd_all("R7_left_wins");
      wr2(1, 5, 1, 0, 0, 0);
      rd2(5, 5, "R7_right_pending_granted");
      wr2(0, 0, 0, 1, 5, 1);
      rd2(5, 5, "R7_released");

      // R9 illegal enable pair: read stays zero, write is dropped
      @(negedge clk);
      set_l(0, 0, 1, 0, 0, 0, 3'd0, 1'b0);
      push(0, 18'h0, "R9_illegal_read");
      @(negedge clk);
      set_l(0, 0, 0, 1, 0, 0, 3'd3, 1'b0);
      @(negedge clk);
      l_rw = 1'b1;
      @(negedge clk);
      idle_both();
      rd2(3, 3, "R9_illegal_write_dropped");

      // R2 output enable high hides the flag
      wr2(1, 6, 0, 0, 0, 0);
      @(negedge clk);
      set_l(0, 1, 1, 1, 0, 0, 3'd6, 1'b0);
      push(0, 18'h0, "R2_oe_high");
      rd2(6, 6, "R2_oe_low_shows_flag");

      // R4 edge taken after deselect is not a commit
      @(negedge clk);
      set_l(0, 1, 0, 1, 0, 0, 3'd4, 1'b0);
      @(negedge clk);
      l_sel_n = 1'b1;
      @(negedge clk);
      l_rw = 1'b1;
      @(negedge clk);
      idle_both();
      rd2(4, 4, "R4_no_commit_when_deselected");

      // R10 byte-lane selects inactive
      bs = 1'b1;
      wr2(0, 0, 0, 1, 7, 0);
      rd2(7, 7, "R10_lanes_off_claim");
      wr2(0, 0, 0, 1, 7, 1);
      rd2(7, 7, "R10_lanes_off_release");
      bs = 1'b0;
      wr2(1, 6, 1, 0, 0, 0);
      rd_all("R11_all_flags_after_directed");

      // R12 random contention on four flags
      for (int step = 0; step < 300; step++) begin
         bit len, ren, lv, rv;
         int la, ra;
         len = 1'($urandom_range(0, 3) != 0);
         ren = 1'($urandom_range(0, 3) != 0);
         lv  = 1'($urandom_range(0, 1));
         rv  = 1'($urandom_range(0, 1));
         la  = int'($urandom_range(0, 3));
         ra  = ($urandom_range(0, 1) != 0) ? la : int'($urandom_range(0, 3));
         wr2(len, la, lv, ren, ra, rv);
         for (int a = 0; a < 4; a++) rd2(a, a, "R12_random_model");
         rd2(la, 3 - la, "R11_R12_cross_read");
      end

      @(negedge clk);
      idle_both();
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule